// File: doc/BRIEF.md
# Shared External Bus Arbiter with Engine Priority and Turnaround Gaps

This block decides which requester may drive a shared external memory bus next. The requesters are a set of ordinary chip-select ports, numbered 0 to `N_CS-1`, and one prefetch/write-posting engine at index `N_CS`. A requester raises its request line and holds it. When the arbiter grants it, the requester owns the bus until it pulses its own done line. A grant is never taken back in the middle of an access. A request arriving from a higher-priority port while the engine is active waits until the engine reports completion.

After each access, the arbiter inserts an idle gap before the next grant. The length of the gap is the bus-turnaround count configured for the requester that just finished. The gap is skipped when the next winner is the same requester, because the bus then does not change hands.

A single policy bit chooses between two arbitration policies:
- **Fixed priority:** the lowest index wins, so the engine comes last.
- **Round robin:** the requester granted most recently becomes the lowest priority for the next decision.

Bus timing generation belongs to each requester and is not part of this block. Request, done and grant are plain level control pins, not a data stream, so they carry no back-pressure rules.

Top module: `xbus_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set. A bit rises only for a requester whose `req_i` bit was high in the cycle before the grant appears. With an idle bus and no gap pending, the grant appears in the cycle after the request is first seen.
- R2: Once granted, a requester keeps its grant bit until its own `done_i` bit is high during a granted cycle. Request changes and done pulses from other requesters have no effect on the grant. This holds for the engine too: its access is never pre-empted.
- R3: In the cycle after the owner's done, `grant_o` is zero.
- R4: When requester i finishes at cycle t and the next winner is a different requester, the first new grant appears at cycle t + `gap_cycles[i]` + 2. No grant is high while a turnaround countdown is nonzero.
- R5: When the next winner is the same requester that just finished, the countdown is dropped and its grant appears at cycle t + 2, whatever the turnaround count is.
- R6: With `policy_rr` = 0, the lowest-indexed requesting port wins. The engine (index `N_CS`) wins only when no other port requests.
- R7: With `policy_rr` = 1, the search starts at the index just above the last granted one and wraps modulo `N_CS+1`.
- R8: `policy_rr` is sampled at each decision, so the policy can be switched between accesses.
- R9: A port that requests while the engine owns the bus is granted at most `gap_cycles[N_CS]` + 2 cycles after the engine's done, provided it is the only requester left.
- R10: After reset, no grant is high, no gap is pending, and the round-robin state is as if the engine were granted last. The first round-robin decision therefore starts its search at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_rr | input | 1 | 0 = fixed priority, 1 = round robin |
| req_i | input | N_CS+1 | Request per requester; the top bit is the engine |
| done_i | input | N_CS+1 | End-of-access pulse per requester; used only while that requester is granted |
| gap_cycles | input | (N_CS+1) x TA_W | Turnaround idle count per requester's chip-select |
| grant_o | output | N_CS+1 | One-hot bus grant |

## Verification
Decisions are tried with every nonzero request pattern of a four-requester configuration, under both policies. Each fixed-priority result is compared with the lowest set bit. Each round-robin result is compared with a rotation from the last winner, which separates a stale pointer from a correct one. Gap timing is swept over every owner and every turnaround count 0 to 7, with a different follower and with the same follower. This separates an off-by-one countdown, a countdown taken from the wrong chip-select, and a missing skip. A final scenario holds the engine granted while a higher-priority port requests and stray done pulses arrive, and then measures the wait after the engine completes.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    POL_FIXED  = 1'b0,
    POL_ROTATE = 1'b1
  } arb_policy_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  input  logic             rotate,
  input  logic [IDX_W-1:0] last_idx,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx
);
  // Search order: 0..N-1 for fixed priority, last+1.. wrapping for rotation.
  always_comb begin
    int base;
    win_vld = 1'b0;
    win_idx = '0;
    base = rotate ? int'(last_idx) + 1 : 0;
    for (int k = 0; k < N_REQ; k++) begin
      int cand;
      cand = (base + k) % N_REQ;
      if (!win_vld && req[cand]) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/arb_gap.sv
module arb_gap #(
  parameter int TA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TA_W-1:0] load_val,
  input  logic            clr,
  output logic            busy
);
  logic [TA_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (clr)        cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - TA_W'(1);
  end

  assign busy = (cnt != '0);

  // R4: the countdown falls by one each idle cycle.
  assert_gap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !clr) |=> (cnt == $past(cnt) - TA_W'(1)));
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
  parameter int N_CS = 3,
  parameter int TA_W = 3,
  localparam int N_REQ = N_CS + 1,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       policy_rr,
  input  logic [N_REQ-1:0]           req_i,
  input  logic [N_REQ-1:0]           done_i,
  input  logic [N_REQ-1:0][TA_W-1:0] gap_cycles,
  output logic [N_REQ-1:0]           grant_o
);
  import arb_pkg::*;

  logic             owner_vld;
  logic [IDX_W-1:0] owner_idx;
  logic [IDX_W-1:0] last_idx;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             gap_busy;
  logic             finish;
  logic             start;
  arb_policy_e      pol;

  assign pol = arb_policy_e'(policy_rr);

  arb_pick #(.N_REQ(N_REQ)) u_pick (
    .req      (req_i),
    .rotate   (pol == POL_ROTATE),
    .last_idx (last_idx),
    .win_vld  (win_vld),
    .win_idx  (win_idx)
  );

  assign finish = owner_vld && done_i[owner_idx];
  assign start  = !owner_vld && win_vld && (!gap_busy || (win_idx == last_idx));

  arb_gap #(.TA_W(TA_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (finish),
    .load_val (gap_cycles[owner_idx]),
    .clr      (start),
    .busy     (gap_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_idx <= '0;
      last_idx  <= IDX_W'(N_REQ - 1);
    end else if (finish) begin
      owner_vld <= 1'b0;
    end else if (start) begin
      owner_vld <= 1'b1;
      owner_idx <= win_idx;
      last_idx  <= win_idx;
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_grant
    assign grant_o[g] = owner_vld && (owner_idx == IDX_W'(g));
  end

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_had_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~$past(grant_o)) != '0) |-> ((grant_o & $past(req_i)) == grant_o));

  assert_no_preempt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && ((grant_o & done_i) == '0)) |=> (grant_o == $past(grant_o)));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & done_i) != '0) |=> (grant_o == '0));

  assert_quiet_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> (grant_o == '0));
endmodule

// File: tb/tb_xbus_arbiter.sv
module tb_xbus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N_CS = 3;
  localparam int TA_W = 3;
  localparam int N_REQ = N_CS + 1;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy_rr = 1'b0;
  logic [N_REQ-1:0] req_i = '0;
  logic [N_REQ-1:0] done_i = '0;
  logic [N_REQ-1:0][TA_W-1:0] gap_cycles = '0;
  logic [N_REQ-1:0] grant_o;

  int checks = 0;
  int fails = 0;
  int cyc_total = 0;
  int last_model = N_REQ - 1;

  xbus_arbiter #(.N_CS(N_CS), .TA_W(TA_W)) dut (
    .clk(clk), .rst_n(rst_n), .policy_rr(policy_rr), .req_i(req_i),
    .done_i(done_i), .gap_cycles(gap_cycles), .grant_o(grant_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc_total, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pick(int pat, int rr, int last);
    int base = rr ? last + 1 : 0;
    for (int k = 0; k < N_REQ; k++) begin
      int c = (base + k) % N_REQ;
      if (pat[c]) return c;
    end
    return -1;
  endfunction

  task automatic wait_grant(inout int cyc);
    while (grant_o == '0 && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic release_bus();
    if (grant_o != '0) begin
      done_i = grant_o;
      req_i = '0;
      @(negedge clk);
      done_i = '0;
    end
  endtask

  initial begin
    int cyc;
    int exp;
    int fol;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset grant", int'(grant_o), 0);

    // R10: the first rotating decision starts at index 0.
    policy_rr = 1'b1;
    req_i = '1;
    cyc = 0;
    wait_grant(cyc);
    check("R10 first rr winner", int'(grant_o), 1);
    check("R1 idle latency", cyc, 1);
    last_model = 0;
    release_bus();

    // R6/R7/R8: every nonzero request pattern under both policies.
    for (int pol = 0; pol < 2; pol++) begin
      for (int pat = 1; pat < (1 << N_REQ); pat++) begin
        while (grant_o != '0) @(negedge clk);
        policy_rr = pol[0];
        req_i = N_REQ'(pat);
        cyc = 0;
        wait_grant(cyc);
        exp = pick(pat, pol, last_model);
        check(pol ? "R7 rr winner" : "R6 fixed winner", int'(grant_o), 1 << exp);
        last_model = exp;
        release_bus();
      end
    end

    // R4/R5: gap length for every owner and count; different and same follower.
    policy_rr = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      for (int t = 0; t < 8; t++) begin
        for (int same = 0; same < 2; same++) begin
          release_bus();
          gap_cycles = '0;
          gap_cycles[i] = TA_W'(t);
          req_i = N_REQ'(1 << i);
          cyc = 0;
          wait_grant(cyc);
          check("R1 owner granted", int'(grant_o), 1 << i);
          fol = same ? i : (i + 1) % N_REQ;
          done_i = N_REQ'(1 << i);
          req_i = N_REQ'(1 << fol);
          @(negedge clk);
          done_i = '0;
          cyc = 1;
          check("R3 grant drops", int'(grant_o), 0);
          wait_grant(cyc);
          if (same) check("R5 skip gap", cyc, 2);
          else      check("R4 gap length", cyc, t + 2);
          check("R4 follower grant", int'(grant_o), 1 << fol);
        end
      end
    end

    // R2/R9: engine held against a higher-priority port and stray done pulses.
    release_bus();
    repeat (10) @(negedge clk);
    gap_cycles = '0;
    gap_cycles[N_CS] = TA_W'(5);
    req_i = N_REQ'(1 << N_CS);
    cyc = 0;
    wait_grant(cyc);
    check("R6 engine alone", int'(grant_o), 1 << N_CS);
    req_i = N_REQ'((1 << N_CS) | 1);
    for (int k = 0; k < 6; k++) begin
      done_i = N_REQ'(k[0] ? 2 : 1);
      @(negedge clk);
      check("R2 engine kept", int'(grant_o), 1 << N_CS);
    end
    done_i = N_REQ'(1 << N_CS);
    req_i = N_REQ'(1);
    @(negedge clk);
    done_i = '0;
    cyc = 1;
    wait_grant(cyc);
    check("R9 wait after engine", cyc, 5 + 2);
    check("R9 port granted", int'(grant_o), 1);
    release_bus();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule